// File: doc/BRIEF.md
# Machine Cycle Sequencer with Request Arbitration

This block is the control sequencer of a small 8-bit processor core. It steps the core through four kinds of machine cycle: instruction fetch, instruction execute, DMA transfer and interrupt entry. Each machine cycle lasts a fixed number of clocks. Within each cycle the block emits one address-strobe pulse (`tpa`) and, later, one data-strobe pulse (`tpb`). A two-bit state code tells the rest of the chip which kind of cycle is running.

At the data strobe the sequencer samples the DMA-in, DMA-out and interrupt request lines, but only in the cycle types that allow it. At the end of the cycle it picks the next one. The order of precedence is: an unfinished instruction, then DMA-in, then DMA-out, then an enabled interrupt, then fetch. The sequencer also holds the small register set these cycles touch:
- a 16-bit DMA pointer, which gives the address of each DMA cycle and advances after it;
- the data and program designators;
- the save register;
- the master interrupt enable.

It also latches four external flags once per fetch for the branch logic. Instruction decode and the ALU lie outside the block. An abstract execute unit reports through `instr_done` that the current instruction has finished, and it can set the interrupt enable through `ie_set`.

Top module: `mcyc_seq`

## Requirements
- R1: `state_code` encodes fetch as 2'b00, execute as 2'b01, DMA as 2'b10 and interrupt as 2'b11, with bit 1 the high state-code line. It changes only at a cycle boundary, so it is already stable when `tpa` rises. The first cycle after reset is a fetch.
- R2: Every machine cycle is 8 clocks long. `tpa` is high for exactly one clock (clock 1 of the cycle, counting from 0) and `tpb` for exactly one clock (clock 6), so `tpb` follows `tpa` by 5 clocks. The two pulses are never high together.
- R3: A fetch is always followed by an execute. An execute cycle in which `instr_done` was low at `tpb` is followed by another execute cycle, and no DMA or interrupt cycle is entered until the instruction is done.
- R4: The DMA requests are sampled only at `tpb` of execute, DMA and interrupt cycles. The interrupt request is sampled only at `tpb` of execute and DMA cycles. A request that is high during a fetch but low at the next sampling point has no effect.
- R5: When several requests are sampled together, DMA-in wins over DMA-out, and DMA-out wins over an interrupt. During a DMA cycle `dma_is_in` is 1 for an inbound transfer and 0 for an outbound one.
- R6: Interrupt requests are not stored. If the interrupt line is low at `tpb` of a DMA cycle that served a concurrent request, the next cycle is a fetch and the interrupt registers do not change.
- R7: An interrupt cycle lasts one machine cycle. At its end `t_save` receives {x_sel, p_sel} as they were before the cycle, `x_sel` becomes 2, `p_sel` becomes 1 and `mie` becomes 0.
- R8: An interrupt cycle is entered only while `mie` is 1. `ie_set` sets `mie`.
- R9: `r0_addr` is the address of each DMA cycle and increases by one at the end of that cycle and at no other time. A DMA request sampled in a DMA cycle leads straight into another DMA cycle.
- R10: `flags_q` takes the value of `flags_in` at the last clock of each fetch cycle and holds it through all other cycles.
- R11: Reset sets `r0_addr`, `x_sel`, `p_sel`, `t_save`, `mie` and `flags_q` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Execute unit: current instruction finishes in this execute cycle |
| ie_set | input | 1 | Execute unit: set the master interrupt enable |
| dma_in_req | input | 1 | Inbound DMA request |
| dma_out_req | input | 1 | Outbound DMA request |
| int_req | input | 1 | Interrupt request, level sensitive and not stored |
| flags_in | input | 4 | External flag inputs |
| state_code | output | 2 | Current machine cycle type |
| tpa | output | 1 | Address strobe pulse, clock 1 of each cycle |
| tpb | output | 1 | Data strobe pulse, clock 6 of each cycle |
| dma_is_in | output | 1 | Direction of the current DMA cycle, 1 for inbound |
| r0_addr | output | 16 | DMA pointer and DMA cycle address |
| x_sel | output | 4 | Data designator |
| p_sel | output | 4 | Program designator |
| t_save | output | 8 | Save register, {x, p} from interrupt entry |
| mie | output | 1 | Master interrupt enable |
| flags_q | output | 4 | Flags latched at the end of the last fetch |

## Verification
The bound checker enforces the following on every clock:
- the two strobes never overlap, and the state code is stable at `tpa`;
- a fetch is always followed by an execute;
- an interrupt cycle starts only with `mie` set, and leaves the designators at 2 and 1 with `mie` cleared;
- the DMA pointer moves only by one, and only at the end of a DMA cycle;
- the flags change only as a fetch ends.

The directed scenarios are needed to show how the sampling windows and the arbitration play out over several cycles. They cover the priority between concurrent requests, the loss of a dropped interrupt after DMA, requests ignored in fetch, chained DMA cycles, and the exact value saved into `t_save`.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
   typedef enum logic [1:0] {
      ST_FETCH = 2'b00,
      ST_EXEC  = 2'b01,
      ST_DMA   = 2'b10,
      ST_INT   = 2'b11
   } mcyc_state_e;
endpackage

// File: rtl/mcyc_timer.sv
module mcyc_timer #(
   parameter int CYC_LEN  = 8,
   parameter int TPA_SLOT = 1,
   parameter int TPB_SLOT = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tpa,
   output logic tpb,
   output logic cyc_end
);
   localparam int SLOT_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(CYC_LEN - 1);

   if (CYC_LEN < 4) begin : g_len_err
      $error("mcyc_timer: CYC_LEN must be at least 4");
   end
   if (!(TPA_SLOT < TPB_SLOT && TPB_SLOT < CYC_LEN - 1)) begin : g_slot_err
      $error("mcyc_timer: need TPA_SLOT < TPB_SLOT < CYC_LEN-1");
   end

   logic [SLOT_W-1:0] slot;

   assign cyc_end = (slot == LAST);
   assign tpa     = (slot == SLOT_W'(TPA_SLOT));
   assign tpb     = (slot == SLOT_W'(TPB_SLOT));

   if ((CYC_LEN & (CYC_LEN - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk) begin
         if (!rst_n) slot <= '0;
         else        slot <= slot + 1'b1;
      end
   end else begin : g_mod
      always_ff @(posedge clk) begin
         if (!rst_n)       slot <= '0;
         else if (cyc_end) slot <= '0;
         else              slot <= slot + 1'b1;
      end
   end
endmodule

// File: rtl/mcyc_arb.sv
module mcyc_arb
   import mcyc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tpb_now,
   input  logic        cyc_end,
   input  logic        instr_done,
   input  logic        dma_in_req,
   input  logic        dma_out_req,
   input  logic        int_req,
   input  logic        mie,
   output mcyc_state_e state,
   output logic        dma_is_in,
   output logic        fetch_end,
   output logic        dma_end,
   output logic        int_end
);
   logic        done_s, din_s, dout_s, int_s;
   mcyc_state_e nxt;

   always_comb begin
      nxt = ST_FETCH;
      if (state == ST_FETCH)        nxt = ST_EXEC;
      else if (!done_s)             nxt = ST_EXEC;
      else if (din_s || dout_s)     nxt = ST_DMA;
      else if (int_s && mie)        nxt = ST_INT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_FETCH;
         dma_is_in <= 1'b0;
         done_s    <= 1'b1;
         din_s     <= 1'b0;
         dout_s    <= 1'b0;
         int_s     <= 1'b0;
      end else if (cyc_end) begin
         state     <= nxt;
         dma_is_in <= (nxt == ST_DMA) && din_s;
         done_s    <= 1'b1;
         din_s     <= 1'b0;
         dout_s    <= 1'b0;
         int_s     <= 1'b0;
      end else if (tpb_now) begin
         done_s <= (state != ST_EXEC) || instr_done;
         din_s  <= (state != ST_FETCH) && dma_in_req;
         dout_s <= (state != ST_FETCH) && dma_out_req;
         int_s  <= (state == ST_EXEC || state == ST_DMA) && int_req;
      end
   end

   assign fetch_end = cyc_end && (state == ST_FETCH);
   assign dma_end   = cyc_end && (state == ST_DMA);
   assign int_end   = cyc_end && (state == ST_INT);
endmodule

// File: rtl/mcyc_regs.sv
module mcyc_regs #(
   parameter int ADDR_W  = 16,
   parameter int DESIG_W = 4,
   parameter int FLAG_N  = 4,
   parameter int INT_X   = 2,
   parameter int INT_P   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fetch_end,
   input  logic                 dma_end,
   input  logic                 int_end,
   input  logic                 ie_set,
   input  logic [FLAG_N-1:0]    flags_in,
   output logic [ADDR_W-1:0]    r0_addr,
   output logic [DESIG_W-1:0]   x_sel,
   output logic [DESIG_W-1:0]   p_sel,
   output logic [2*DESIG_W-1:0] t_save,
   output logic                 mie,
   output logic [FLAG_N-1:0]    flags_q
);
   if (INT_X >= (1 << DESIG_W) || INT_P >= (1 << DESIG_W)) begin : g_desig_err
      $error("mcyc_regs: interrupt designators do not fit DESIG_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       r0_addr <= '0;
      else if (dma_end) r0_addr <= r0_addr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_sel  <= '0;
         p_sel  <= '0;
         t_save <= '0;
         mie    <= 1'b0;
      end else if (int_end) begin
         t_save <= {x_sel, p_sel};
         x_sel  <= DESIG_W'(INT_X);
         p_sel  <= DESIG_W'(INT_P);
         mie    <= 1'b0;
      end else if (ie_set) begin
         mie    <= 1'b1;
      end
   end

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)         flags_q[i] <= 1'b0;
         else if (fetch_end) flags_q[i] <= flags_in[i];
      end
   end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DESIG_W  = 4,
   parameter int FLAG_N   = 4,
   parameter int CYC_LEN  = 8,
   parameter int TPA_SLOT = 1,
   parameter int TPB_SLOT = 6,
   parameter int INT_X    = 2,
   parameter int INT_P    = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_done,
   input  logic                 ie_set,
   input  logic                 dma_in_req,
   input  logic                 dma_out_req,
   input  logic                 int_req,
   input  logic [FLAG_N-1:0]    flags_in,
   output logic [1:0]           state_code,
   output logic                 tpa,
   output logic                 tpb,
   output logic                 dma_is_in,
   output logic [ADDR_W-1:0]    r0_addr,
   output logic [DESIG_W-1:0]   x_sel,
   output logic [DESIG_W-1:0]   p_sel,
   output logic [2*DESIG_W-1:0] t_save,
   output logic                 mie,
   output logic [FLAG_N-1:0]    flags_q
);
   logic        cyc_end, fetch_end, dma_end, int_end;
   mcyc_state_e state;

   mcyc_timer #(
      .CYC_LEN(CYC_LEN), .TPA_SLOT(TPA_SLOT), .TPB_SLOT(TPB_SLOT)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .tpa(tpa), .tpb(tpb), .cyc_end(cyc_end)
   );

   mcyc_arb u_arb (
      .clk(clk), .rst_n(rst_n), .tpb_now(tpb), .cyc_end(cyc_end),
      .instr_done(instr_done), .dma_in_req(dma_in_req),
      .dma_out_req(dma_out_req), .int_req(int_req), .mie(mie),
      .state(state), .dma_is_in(dma_is_in), .fetch_end(fetch_end),
      .dma_end(dma_end), .int_end(int_end)
   );

   mcyc_regs #(
      .ADDR_W(ADDR_W), .DESIG_W(DESIG_W), .FLAG_N(FLAG_N),
      .INT_X(INT_X), .INT_P(INT_P)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .fetch_end(fetch_end), .dma_end(dma_end),
      .int_end(int_end), .ie_set(ie_set), .flags_in(flags_in),
      .r0_addr(r0_addr), .x_sel(x_sel), .p_sel(p_sel), .t_save(t_save),
      .mie(mie), .flags_q(flags_q)
   );

   assign state_code = state;
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk #(
   parameter int ADDR_W  = 16,
   parameter int DESIG_W = 4,
   parameter int FLAG_N  = 4,
   parameter int INT_X   = 2,
   parameter int INT_P   = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           state_code,
   input logic                 tpa,
   input logic                 tpb,
   input logic [ADDR_W-1:0]    r0_addr,
   input logic [DESIG_W-1:0]   x_sel,
   input logic [DESIG_W-1:0]   p_sel,
   input logic                 mie,
   input logic [FLAG_N-1:0]    flags_q
);
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tpa && tpb)); // R2

   AST_SC_STABLE_AT_TPA: assert property (@(posedge clk) disable iff (!rst_n)
      tpa |-> $stable(state_code)); // R1

   AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_code) == 2'b00 && state_code != 2'b00) |-> state_code == 2'b01); // R3

   AST_INT_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b11 && $past(state_code) != 2'b11) |-> $past(mie)); // R8

   AST_INT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_code) == 2'b11 && state_code != 2'b11) |->
      (x_sel == DESIG_W'(INT_X) && p_sel == DESIG_W'(INT_P) && !mie)); // R7

   AST_R0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (r0_addr != $past(r0_addr)) |->
      ($past(state_code) == 2'b10 && r0_addr == ADDR_W'($past(r0_addr) + 1'b1))); // R9

   AST_FLAGS_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q != $past(flags_q)) |-> $past(state_code) == 2'b00); // R10
endmodule

bind mcyc_seq mcyc_seq_chk #(
   .ADDR_W(ADDR_W), .DESIG_W(DESIG_W), .FLAG_N(FLAG_N),
   .INT_X(INT_X), .INT_P(INT_P)
) u_chk (
   .clk(clk), .rst_n(rst_n), .state_code(state_code), .tpa(tpa), .tpb(tpb),
   .r0_addr(r0_addr), .x_sel(x_sel), .p_sel(p_sel), .mie(mie), .flags_q(flags_q)
);

// File: tb/mcyc_seq_tb.sv
`timescale 1ns/1ps
module mcyc_seq_tb;
   localparam logic [1:0] FE = 2'b00, EX = 2'b01, DM = 2'b10, IN = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_done = 1'b1, ie_set = 1'b0;
   logic        dma_in_req = 1'b0, dma_out_req = 1'b0, int_req = 1'b0;
   logic [3:0]  flags_in = 4'h0;
   logic [1:0]  state_code;
   logic        tpa, tpb, dma_is_in, mie;
   logic [15:0] r0_addr;
   logic [3:0]  x_sel, p_sel, flags_q;
   logic [7:0]  t_save;

   int checks = 0, failures = 0;
   logic [1:0] cur;

   always #5 clk = ~clk;

   mcyc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ie_set(ie_set),
      .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .int_req(int_req),
      .flags_in(flags_in), .state_code(state_code), .tpa(tpa), .tpb(tpb),
      .dma_is_in(dma_is_in), .r0_addr(r0_addr), .x_sel(x_sel), .p_sel(p_sel),
      .t_save(t_save), .mie(mie), .flags_q(flags_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // advance to the negedge inside the next tpa clock
   task automatic next_cyc();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tpa && n < 20);
      if (!tpa) chk("R2 tpa missing", 0, 1);
      cur = state_code;
   endtask

   task automatic to_fetch();
      for (int i = 0; i < 10 && cur != FE; i++) next_cyc();
   endtask

   task automatic pulse_ie();
      ie_set = 1'b1;
      @(negedge clk);
      ie_set = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 reset state", state_code, FE);
      chk("R11 r0", r0_addr, 0);
      chk("R11 x", x_sel, 0);
      chk("R11 p", p_sel, 0);
      chk("R11 t", t_save, 0);
      chk("R11 mie", mie, 0);
      chk("R11 flags", flags_q, 0);
      rst_n = 1'b1;
      next_cyc();
      chk("R1 first cycle fetch", cur, FE);
   endtask

   task automatic t_timing();
      int na = 0, nb = 0, gap = -1;
      for (int i = 0; i < 8; i++) begin
         if (tpa) na++;
         if (tpb) begin nb++; gap = i; end
         if (tpa && tpb) chk("R2 overlap", 1, 0);
         @(negedge clk);
      end
      chk("R2 tpa count", na, 1);
      chk("R2 tpb count", nb, 1);
      chk("R2 tpb after tpa", gap, 5);
      chk("R2 cycle length", tpa, 1);
      cur = state_code;
      chk("R3 fetch then exec", cur, EX);
   endtask

   task automatic t_multi_dma();
      to_fetch();
      instr_done = 1'b0; dma_in_req = 1'b1;
      next_cyc(); chk("R3 exec", cur, EX);
      next_cyc(); chk("R3 exec repeats until done", cur, EX);
      instr_done = 1'b1;
      next_cyc(); chk("R9 dma entered", cur, DM);
      chk("R5 dma in direction", dma_is_in, 1);
      chk("R9 r0 before step", r0_addr, 0);
      next_cyc(); chk("R9 chained dma", cur, DM);
      chk("R9 r0 step", r0_addr, 1);
      dma_in_req = 1'b0;
      next_cyc(); chk("R9 dma ends to fetch", cur, FE);
      chk("R9 r0 second step", r0_addr, 2);
   endtask

   task automatic t_fetch_ignored();
      to_fetch();
      dma_in_req = 1'b1; int_req = 1'b1;
      next_cyc(); chk("R4 exec", cur, EX);
      dma_in_req = 1'b0; int_req = 1'b0;
      next_cyc(); chk("R4 fetch request ignored", cur, FE);
      chk("R4 r0 unchanged", r0_addr, 2);
   endtask

   task automatic t_priority();
      to_fetch();
      next_cyc();
      dma_in_req = 1'b1; dma_out_req = 1'b1; int_req = 1'b1;
      next_cyc(); chk("R5 dma wins", cur, DM);
      chk("R5 in over out", dma_is_in, 1);
      dma_in_req = 1'b0;
      next_cyc(); chk("R5 out next", cur, DM);
      chk("R5 out direction", dma_is_in, 0);
      dma_out_req = 1'b0; int_req = 1'b0;
      next_cyc(); chk("R5 back to fetch", cur, FE);
      chk("R9 r0 after two", r0_addr, 4);
   endtask

   task automatic t_int_masked();
      to_fetch();
      next_cyc();
      int_req = 1'b1;
      next_cyc(); chk("R8 masked interrupt", cur, FE);
      chk("R8 x unchanged", x_sel, 0);
      int_req = 1'b0;
   endtask

   task automatic t_int_entry();
      to_fetch();
      pulse_ie();
      chk("R8 ie_set", mie, 1);
      next_cyc(); chk("R7 exec", cur, EX);
      int_req = 1'b1;
      next_cyc(); chk("R7 interrupt cycle", cur, IN);
      next_cyc(); chk("R7 one cycle then fetch", cur, FE);
      chk("R7 t saved", t_save, 8'h00);
      chk("R7 x", x_sel, 2);
      chk("R7 p", p_sel, 1);
      chk("R7 mie cleared", mie, 0);
      next_cyc(); chk("R8 exec", cur, EX);
      next_cyc(); chk("R8 no reentry with mie clear", cur, FE);
      pulse_ie();
      next_cyc();
      next_cyc(); chk("R7 second interrupt", cur, IN);
      int_req = 1'b0;
      next_cyc(); chk("R7 t holds old x,p", t_save, 8'h21);
   endtask

   task automatic t_int_lost();
      to_fetch();
      pulse_ie();
      next_cyc();
      dma_out_req = 1'b1; int_req = 1'b1;
      next_cyc(); chk("R5 dma over interrupt", cur, DM);
      dma_out_req = 1'b0; int_req = 1'b0;
      next_cyc(); chk("R6 dropped interrupt lost", cur, FE);
      chk("R6 mie kept", mie, 1);
      chk("R6 t unchanged", t_save, 8'h21);
      next_cyc();
      dma_out_req = 1'b1; int_req = 1'b1;
      next_cyc(); chk("R6 dma first", cur, DM);
      dma_out_req = 1'b0;
      next_cyc(); chk("R6 held interrupt served", cur, IN);
      int_req = 1'b0; dma_in_req = 1'b1;
      next_cyc(); chk("R4 dma sampled in interrupt cycle", cur, DM);
      dma_in_req = 1'b0;
      next_cyc(); chk("R4 fetch", cur, FE);
   endtask

   task automatic t_flags();
      to_fetch();
      flags_in = 4'hA;
      next_cyc(); chk("R10 flags latched at fetch end", flags_q, 4'hA);
      flags_in = 4'h5;
      next_cyc(); chk("R10 flags held outside fetch", flags_q, 4'hA);
      to_fetch();
      next_cyc(); chk("R10 new flags", flags_q, 4'h5);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      cur = FE;
      repeat (3) @(negedge clk);
      t_reset();
      t_timing();
      t_multi_dma();
      t_fetch_ignored();
      t_priority();
      t_int_masked();
      t_int_entry();
      t_int_lost();
      t_flags();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule